// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small 8-bit processor core and picks which hardware interrupt the core should service. It has five request lines. One line cannot be masked. Four can be masked, and they are ranked in a fixed order. Each line has its own trigger style:

- **Non-maskable line:** edge plus level. A rising edge arms it, and the line must still be high when the request is raised.
- **Top maskable line:** a rising edge sets a latch, and the request comes from that latch.
- **Other three lines:** plain levels.

Each input is brought into the clock domain through a two-flop synchronizer.

The core controls the block with three things:

- a one-cycle enable pulse and a one-cycle disable pulse for the global maskable enable;
- a packed control byte that sets masks, clears the edge latch and drives a serial output bit.

It reads back a packed status byte. When a source wins, the block gives a one-cycle request pulse. The pulse carries the source number and that source's fixed service address. No further request is raised until the core returns an acknowledge.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the three masks are 1 (masked) and the global enable is 0. The edge latch and serial output are 0, `req_o` is 0, and `stat_o` reads 8'h07 while `ser_in_i` is 0.
- R2: Priority runs in the order `irq_i[0]` (non-maskable, id 0), `irq_i[1]` (edge-latched, id 1), `irq_i[2]` (id 2), `irq_i[3]` (id 3), `irq_i[4]` (general, id 4). The lowest index wins and its id appears on `req_src_o`.
- R3: `req_vec_o` is 16'h0024 for id 0, 16'h003C for id 1, 16'h0034 for id 2, 16'h002C for id 3 and 16'h0000 for id 4.
- R4: The non-maskable line is requested only after a synchronized rising edge, and only while the line is still high. A one-cycle pulse is not taken. This line ignores the masks and the global enable. Taking it clears the global enable.
- R5: The `irq_i[1]` latch sets on a synchronized rising edge even while masked. It is cleared when that source is taken, or by a control write with bit4 = 1.
- R6: `irq_i[2]` and `irq_i[3]` are level requests that need the global enable set and their own mask at 0. `irq_i[1]` needs the same enable and mask. `irq_i[4]` needs only the global enable; the masks have no effect on it.
- R7: A control write (`mask_wr_i`) loads bits 2, 1, 0 into the masks for `irq_i[1]`, `irq_i[2]` and `irq_i[3]`, but only when bit3 = 1. Bit5 has no effect.
- R8: On a control write with bit6 = 1, bit7 is copied to `ser_out_o`. With bit6 = 0, `ser_out_o` is unchanged.
- R9: The `stat_o` bits are:
  - bit7: synchronized `ser_in_i`;
  - bit6: the `irq_i[1]` latch;
  - bits 5 and 4: synchronized `irq_i[2]` and `irq_i[3]`;
  - bit3: the global enable;
  - bits 2 to 0: the masks for `irq_i[1]`, `irq_i[2]` and `irq_i[3]`.
- R10: `ie_set_i` sets the global enable and `ie_clr_i` clears it. Taking any source clears it, and it stays clear until the next `ie_set_i`.
- R11: `req_o` is high for exactly one cycle. No new request is raised from then until `ack_i` has been seen.
- R12: Latency is counted in clock edges from a change at the inputs. Requests from level lines appear on the 3rd edge. Requests from the edge-triggered lines (`irq_i[0]`, `irq_i[1]`) appear on the 4th edge. Status bits 7, 5 and 4 follow their inputs on the 2nd edge, and bit6 on the 3rd edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 5 | Request lines, index 0 highest priority |
| ser_in_i | input | 1 | Serial input bit reported in status bit7 |
| ie_set_i | input | 1 | Global enable set command |
| ie_clr_i | input | 1 | Global enable clear command |
| mask_wr_i | input | 1 | Control byte write strobe |
| mask_byte_i | input | 8 | Control byte |
| ack_i | input | 1 | Core accepted the outstanding request |
| req_o | output | 1 | One-cycle request pulse |
| req_src_o | output | 3 | Id of the winning source |
| req_vec_o | output | 16 | Fixed service address of the winner |
| stat_o | output | 8 | Packed status byte |
| ser_out_o | output | 1 | Serial output bit |

## Verification
Every result has a fixed delay, counted in rising edges after the input was driven on a falling edge:

| Result | Due on edge |
|---|---|
| Register write (masks, serial output, enable) | 1st |
| Synchronized status bits | 2nd |
| Level-line request | 3rd |
| Edge-latch status bit and edge-line requests | 4th |
| Request after an acknowledge releases the block | 2nd |

The bench drives on falling edges and samples on the following falling edges. It records the edge index at which `req_o` first rises and compares it with the expected delay. It also counts how many cycles `req_o` is high within the watch window, which must be exactly one. Status latency is checked on both sides: one falling edge before the status bit is due, where it must still be 0, and on the falling edge when it is due.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NSRC   = 5;
    localparam int SRC_W  = 3;
    localparam int VEC_W  = 16;
    localparam int BYTE_W = 8;

    // Control byte bit positions
    localparam int CB_SOD  = 7;
    localparam int CB_SDE  = 6;
    localparam int CB_CLR  = 4;
    localparam int CB_MEN  = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NMI  = 3'd0,
        SRC_EDGE = 3'd1,
        SRC_LVA  = 3'd2,
        SRC_LVB  = 3'd3,
        SRC_GEN  = 3'd4
    } src_e;

    typedef struct packed {
        logic [2:0]       mask;      // [2]=edge line, [1]=level A, [0]=level B
        logic             ie;
        logic             nmi_lat;
        logic             nmi_prev;
        logic             edge_lat;
        logic             edge_prev;
        logic             ser_out;
        logic             busy;
        logic             req;
        src_e             src;
        logic [VEC_W-1:0] vec;
    } ctrl_t;

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        case (s)
            SRC_NMI:  vec_of = 16'h0024;
            SRC_EDGE: vec_of = 16'h003C;
            SRC_LVA:  vec_of = 16'h0034;
            SRC_LVB:  vec_of = 16'h002C;
            default:  vec_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sh_q;
        logic [STAGES-1:0] sh_d;

        always_comb begin
            sh_d = (sh_q << 1) | STAGES'(async_i[i]);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign sync_o[i] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        // Walk from lowest priority upward so the lowest index is kept last
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_i,
    input  logic              ser_in_i,
    input  logic              ie_set_i,
    input  logic              ie_clr_i,
    input  logic              mask_wr_i,
    input  logic [BYTE_W-1:0] mask_byte_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic [SRC_W-1:0]  req_src_o,
    output logic [VEC_W-1:0]  req_vec_o,
    output logic [BYTE_W-1:0] stat_o,
    output logic              ser_out_o
);

    localparam int SYNC_W = NSRC + 1;   // request lines plus serial input

    logic [SYNC_W-1:0] sync;
    logic [NSRC-1:0]   cand;
    logic              pick_any;
    logic [SRC_W-1:0]  pick_idx;
    logic              rise_nmi;
    logic              rise_edge;
    logic              unused_ctrl_bit;
    ctrl_t             st_q;
    ctrl_t             st_d;

    assign unused_ctrl_bit = mask_byte_i[5];

    irq_sync_bank #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_in_i, irq_i}),
        .sync_o  (sync)
    );

    assign rise_nmi  = sync[SRC_NMI]  & ~st_q.nmi_prev;
    assign rise_edge = sync[SRC_EDGE] & ~st_q.edge_prev;

    // Eligible sources, from registered state and synchronized levels
    always_comb begin
        cand            = '0;
        cand[SRC_NMI]   = st_q.nmi_lat & sync[SRC_NMI];
        cand[SRC_EDGE]  = st_q.edge_lat & ~st_q.mask[2] & st_q.ie;
        cand[SRC_LVA]   = sync[SRC_LVA] & ~st_q.mask[1] & st_q.ie;
        cand[SRC_LVB]   = sync[SRC_LVB] & ~st_q.mask[0] & st_q.ie;
        cand[SRC_GEN]   = sync[SRC_GEN] & st_q.ie;
    end

    irq_prio_pick #(
        .N  (NSRC),
        .IW (SRC_W)
    ) u_pick (
        .cand_i (cand),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.req       = 1'b0;
        st_d.nmi_prev  = sync[SRC_NMI];
        st_d.edge_prev = sync[SRC_EDGE];

        // Global enable commands
        if (ie_set_i)      st_d.ie = 1'b1;
        else if (ie_clr_i) st_d.ie = 1'b0;

        // Control byte
        if (mask_wr_i) begin
            if (mask_byte_i[CB_MEN]) st_d.mask     = mask_byte_i[2:0];
            if (mask_byte_i[CB_SDE]) st_d.ser_out  = mask_byte_i[CB_SOD];
            if (mask_byte_i[CB_CLR]) st_d.edge_lat = 1'b0;
        end

        // Non-maskable arm drops as soon as the line falls
        if (!sync[SRC_NMI]) st_d.nmi_lat = 1'b0;

        // Acknowledge releases the outstanding request
        if (ack_i) st_d.busy = 1'b0;

        // Issue a new request
        if (!st_q.busy && pick_any) begin
            st_d.req  = 1'b1;
            st_d.busy = 1'b1;
            st_d.src  = src_e'(pick_idx);
            st_d.vec  = vec_of(src_e'(pick_idx));
            st_d.ie   = 1'b0;
            if (src_e'(pick_idx) == SRC_NMI)  st_d.nmi_lat  = 1'b0;
            if (src_e'(pick_idx) == SRC_EDGE) st_d.edge_lat = 1'b0;
        end

        // New edges are captured last so none is lost
        if (rise_nmi)  st_d.nmi_lat  = 1'b1;
        if (rise_edge) st_d.edge_lat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 3'b111;
            st_q.src  <= SRC_NMI;
        end else begin
            st_q      <= st_d;
        end
    end

    assign req_o     = st_q.req;
    assign req_src_o = st_q.src;
    assign req_vec_o = st_q.vec;
    assign ser_out_o = st_q.ser_out;
    assign stat_o    = {sync[NSRC], st_q.edge_lat, sync[SRC_LVA], sync[SRC_LVB],
                        st_q.ie, st_q.mask};

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_o,
    input logic [2:0]  req_src_o,
    input logic [15:0] req_vec_o,
    input logic [7:0]  stat_o,
    input logic        ser_out_o,
    input logic        ack_i,
    input logic        mask_wr_i,
    input logic [7:0]  mask_byte_i
);

    logic        out_q;
    logic [15:0] exp_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     out_q <= 1'b0;
        else if (ack_i) out_q <= 1'b0;
        else if (req_o) out_q <= 1'b1;
    end

    always_comb begin
        case (req_src_o)
            3'd0:    exp_vec = 16'h0024;
            3'd1:    exp_vec = 16'h003C;
            3'd2:    exp_vec = 16'h0034;
            3'd3:    exp_vec = 16'h002C;
            default: exp_vec = 16'h0000;
        endcase
    end

    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !out_q);

    assert_vector_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (req_vec_o == exp_vec));

    assert_enable_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !stat_o[3]);

    assert_enable_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_src_o != 3'd0) |-> $past(stat_o[3]));

    assert_mask_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_src_o == 3'd1) |-> !$past(stat_o[2]));

    assert_mask_lva_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_src_o == 3'd2) |-> !$past(stat_o[1]));

    assert_mask_lvb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_src_o == 3'd3) |-> !$past(stat_o[0]));

    assert_ser_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_i && !mask_byte_i[6]) |=> $stable(ser_out_o));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_i && !mask_byte_i[3]) |=> (stat_o[2:0] == $past(stat_o[2:0])));

endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_o       (req_o),
    .req_src_o   (req_src_o),
    .req_vec_o   (req_vec_o),
    .stat_o      (stat_o),
    .ser_out_o   (ser_out_o),
    .ack_i       (ack_i),
    .mask_wr_i   (mask_wr_i),
    .mask_byte_i (mask_byte_i)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_i = '0;
    logic        ser_in_i = 1'b0;
    logic        ie_set_i = 1'b0;
    logic        ie_clr_i = 1'b0;
    logic        mask_wr_i = 1'b0;
    logic [7:0]  mask_byte_i = '0;
    logic        ack_i = 1'b0;
    logic        req_o;
    logic [2:0]  req_src_o;
    logic [15:0] req_vec_o;
    logic [7:0]  stat_o;
    logic        ser_out_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_prio_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .ser_in_i    (ser_in_i),
        .ie_set_i    (ie_set_i),
        .ie_clr_i    (ie_clr_i),
        .mask_wr_i   (mask_wr_i),
        .mask_byte_i (mask_byte_i),
        .ack_i       (ack_i),
        .req_o       (req_o),
        .req_src_o   (req_src_o),
        .req_vec_o   (req_vec_o),
        .stat_o      (stat_o),
        .ser_out_o   (ser_out_o)
    );

    typedef struct packed {
        logic [4:0]  src;
        logic [2:0]  mask;
        logic        ie;
        logic        hit;
        logic [2:0]  esrc;
        logic [15:0] evec;
        logic [3:0]  dly;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{5'b00010, 3'b000, 1'b1, 1'b1, 3'd1, 16'h003C, 4'd4},  // R2 R3 R5 R12
        '{5'b00100, 3'b000, 1'b1, 1'b1, 3'd2, 16'h0034, 4'd3},  // R6 R12
        '{5'b01000, 3'b000, 1'b1, 1'b1, 3'd3, 16'h002C, 4'd3},  // R6
        '{5'b10000, 3'b000, 1'b1, 1'b1, 3'd4, 16'h0000, 4'd3},  // R3 R6
        '{5'b00001, 3'b111, 1'b0, 1'b1, 3'd0, 16'h0024, 4'd4},  // R4 ignores ie/masks
        '{5'b01100, 3'b000, 1'b1, 1'b1, 3'd2, 16'h0034, 4'd3},  // R2
        '{5'b01100, 3'b010, 1'b1, 1'b1, 3'd3, 16'h002C, 4'd3},  // R6 mask
        '{5'b11000, 3'b000, 1'b0, 1'b0, 3'd0, 16'h0000, 4'd0},  // R10 enable off
        '{5'b00011, 3'b000, 1'b1, 1'b1, 3'd0, 16'h0024, 4'd4},  // R2 nmi wins
        '{5'b10100, 3'b111, 1'b1, 1'b1, 3'd4, 16'h0000, 4'd3}   // R6 general ignores masks
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] b);
        mask_wr_i   = 1'b1;
        mask_byte_i = b;
        tick(1);
        mask_wr_i   = 1'b0;
        mask_byte_i = '0;
    endtask

    task automatic ie_cmd(input logic set);
        if (set) ie_set_i = 1'b1; else ie_clr_i = 1'b1;
        tick(1);
        ie_set_i = 1'b0;
        ie_clr_i = 1'b0;
    endtask

    task automatic do_ack();
        ack_i = 1'b1;
        tick(1);
        ack_i = 1'b0;
    endtask

    // Watch req_o for maxk falling edges; record first edge and high count
    task automatic watch(input int maxk, output int k, output int cnt,
                         output logic [2:0] s, output logic [15:0] v);
        k = 0; cnt = 0; s = '0; v = '0;
        for (int i = 1; i <= maxk; i++) begin
            @(negedge clk);
            if (req_o) begin
                cnt++;
                if (k == 0) begin
                    k = i;
                    s = req_src_o;
                    v = req_vec_o;
                end
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k, cnt;
        logic [2:0]  s;
        logic [15:0] v;

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 stat", stat_o, 8'h07);
        chk("R1 req", req_o, 0);
        chk("R1 ser_out", ser_out_o, 0);

        // Vector table
        for (int e = 0; e < NVEC; e++) begin
            wr_ctrl({3'b000, 1'b1, 1'b1, TBL[e].mask});
            ie_cmd(TBL[e].ie);
            irq_i = TBL[e].src;
            watch(8, k, cnt, s, v);
            if (TBL[e].hit) begin
                chk($sformatf("R12 delay e%0d", e), k, TBL[e].dly);
                chk($sformatf("R2 src e%0d", e), s, TBL[e].esrc);
                chk($sformatf("R3 vec e%0d", e), v, TBL[e].evec);
                chk($sformatf("R11 width e%0d", e), cnt, 1);
            end else begin
                chk($sformatf("R10 none e%0d", e), cnt, 0);
            end
            irq_i = '0;
            do_ack();
            tick(5);
        end

        // R7 gating by bit3; bit5 no effect
        wr_ctrl(8'h27);
        wr_ctrl(8'h20);
        chk("R7 masks kept", stat_o[2:0], 3'b111);
        wr_ctrl(8'h0A);
        chk("R7 masks loaded", stat_o[2:0], 3'b010);

        // R8 serial output
        wr_ctrl(8'hC0);
        chk("R8 ser set", ser_out_o, 1);
        wr_ctrl(8'h80);
        chk("R8 ser held", ser_out_o, 1);
        wr_ctrl(8'h40);
        chk("R8 ser clear", ser_out_o, 0);

        // R9 R12 serial input in status
        ser_in_i = 1'b1;
        tick(1);
        chk("R12 sid early", stat_o[7], 0);
        tick(1);
        chk("R9 sid", stat_o[7], 1);
        ser_in_i = 1'b0;
        tick(3);

        // R5 latch sets while masked, cleared on accept
        wr_ctrl(8'h1F);
        ie_cmd(1'b1);
        irq_i[1] = 1'b1;
        tick(2);
        chk("R12 latch early", stat_o[6], 0);
        irq_i[1] = 1'b0;
        tick(1);
        chk("R5 latch masked", stat_o[6], 1);
        watch(6, k, cnt, s, v);
        chk("R5 masked no req", cnt, 0);
        wr_ctrl(8'h0B);
        watch(3, k, cnt, s, v);
        chk("R5 unmask req edge", k, 1);
        chk("R5 unmask src", s, 3'd1);
        chk("R5 latch cleared on accept", stat_o[6], 0);
        chk("R10 ie cleared on accept", stat_o[3], 0);
        do_ack();

        // R5 clear via bit4, masks untouched
        wr_ctrl(8'h0F);
        irq_i[1] = 1'b1;
        tick(4);
        irq_i[1] = 1'b0;
        chk("R5 latch set", stat_o[6], 1);
        wr_ctrl(8'h10);
        chk("R5 latch cleared by write", stat_o[6], 0);
        chk("R7 masks after clear write", stat_o[2:0], 3'b111);
        tick(3);

        // R10 enable commands
        ie_cmd(1'b1);
        chk("R10 ie set", stat_o[3], 1);
        ie_cmd(1'b0);
        chk("R10 ie clear", stat_o[3], 0);

        // R4 short pulse on non-maskable line is not taken
        irq_i[0] = 1'b1;
        tick(1);
        irq_i[0] = 1'b0;
        watch(8, k, cnt, s, v);
        chk("R4 short pulse ignored", cnt, 0);

        // R11 single outstanding; R4 nmi clears enable
        wr_ctrl(8'h08);
        ie_cmd(1'b1);
        irq_i[2] = 1'b1;
        watch(4, k, cnt, s, v);
        chk("R11 first req src", s, 3'd2);
        ie_cmd(1'b1);
        irq_i[0] = 1'b1;
        watch(8, k, cnt, s, v);
        chk("R11 blocked while busy", cnt, 0);
        chk("R10 ie re-set", stat_o[3], 1);
        do_ack();
        watch(3, k, cnt, s, v);
        chk("R11 req after ack edge", k, 1);
        chk("R2 nmi over level", s, 3'd0);
        chk("R3 nmi vec", v, 16'h0024);
        chk("R4 nmi clears ie", stat_o[3], 0);
        do_ack();
        watch(6, k, cnt, s, v);
        chk("R10 level ignored after clear", cnt, 0);
        irq_i = '0;
        tick(3);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule